// File: doc/BRIEF.md
# Keyboard Pin Edge Interrupt Controller

This block watches a small group of external input pins and raises one interrupt request when a selected edge appears on any pin that is switched on. Each pin has an enable bit and a polarity bit. The polarity bit chooses the active edge and the direction of the pad pull resistor that the pin expects. Pin samples pass through a two-flop synchronizer. A sticky pending flag records any qualifying edge. The request output is that flag gated by a global interrupt enable.

Software sets the block up through a four-word register port that has a write strobe and a combinational read. A pin that is switched on at the moment its level crosses can latch a flag that software did not want. For that reason the intended bring-up order is: mask, choose polarity, switch on pulls, enable the pins, acknowledge, and then unmask. The previous-sample register of each pin follows the pin even while the pin is disabled. A steady pin therefore never produces a flag when it is switched on.

Top module: `keypin_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq` is 0 and both pull output vectors are 0.
- R2: Polarity bit 0 selects the falling edge. A high-to-low change on an enabled pin sets the flag (control word bit 2) within four clock cycles.
- R3: Polarity bit 1 selects the rising edge. A low-to-high change on an enabled pin sets the flag.
- R4: An edge opposite to the selected polarity, or any edge on a disabled pin, leaves the flag unchanged.
- R5: `irq` equals the flag ANDed with the interrupt enable (control word bit 0). While the enable is 0 the flag can still be set.
- R6: Writing the control word (address 0) with bit 1 set clears the flag. Bit 1 always reads back as 0.
- R7: If a qualifying edge and an acknowledge write occur in the same cycle, the flag stays set.
- R8: `pull_up[i]` is pull-enable[i] AND NOT polarity[i]. `pull_down[i]` is pull-enable[i] AND polarity[i]. The two are never both high.
- R9: Enabling a pin whose level has been steady sets no flag.
- R10: The register map is: address 0 control {flag at bit 2, ack at bit 1, interrupt enable at bit 0}; address 1 pin enables; address 2 polarity; address 3 pull enables. Pin i maps to bit i, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| pins_in | input | 4 | Asynchronous pin inputs |
| pull_up | output | 4 | Per-pin pullup request |
| pull_down | output | 4 | Per-pin pulldown request |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions assume that `reg_wr` and `reg_addr` are stable around the clock edge, and that `pins_in` may change at any time, because the synchronizer absorbs it. The edge-to-flag property also assumes that the interrupt enable is not rewritten in the same cycle as the edge. The bench drives every input on the falling clock edge. It changes pins only while the register port is idle, except in the one case where an acknowledge is deliberately placed in the cycle of a detected edge.

// File: rtl/kpi_pkg.sv
// Shared constants for the keyboard pin edge interrupt controller.
// Assumes the register data word is at least as wide as the pin count.
package kpi_pkg;
    localparam int KPI_PINS   = 4;
    localparam int KPI_DW     = 8;
    localparam int KPI_AW     = 2;
    localparam int KPI_SYNC   = 2;

    localparam logic [KPI_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [KPI_AW-1:0] ADDR_EN   = 2'd1;
    localparam logic [KPI_AW-1:0] ADDR_POL  = 2'd2;
    localparam logic [KPI_AW-1:0] ADDR_PULL = 2'd3;

    localparam int CTRL_IE   = 0;
    localparam int CTRL_ACK  = 1;
    localparam int CTRL_FLAG = 2;
endpackage

// File: rtl/kpi_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherence is provided.
module kpi_sync #(
    parameter int W      = kpi_pkg::KPI_PINS,
    parameter int STAGES = kpi_pkg::KPI_SYNC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the pin samples through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/kpi_edge.sv
// Per-pin edge detector with a selectable active edge.
// The previous-sample register follows every pin, enabled or not,
// so enabling a steady pin cannot create an edge from stale state.
module kpi_edge #(
    parameter int W = kpi_pkg::KPI_PINS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    input  logic [W-1:0] en,
    input  logic [W-1:0] pol,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev;

    // Keep the last synchronized sample of every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= smp;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall;
        // Qualify the transition against the pin's chosen polarity.
        always_comb begin
            rise   = smp[i] & ~prev[i];
            fall   = ~smp[i] & prev[i];
            hit[i] = en[i] & (pol[i] ? rise : fall);
        end

        assert_hit_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |-> (en[i] && smp[i] == pol[i] && prev[i] != pol[i]));
    end
endmodule

// File: rtl/kpi_regs.sv
// Register file, sticky pending flag and interrupt gate.
// Assumes edge hits arrive already qualified by enable and polarity.
module kpi_regs
    import kpi_pkg::*;
#(
    parameter int W  = KPI_PINS,
    parameter int DW = KPI_DW,
    parameter int AW = KPI_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          hit_any,
    output logic [W-1:0]  pin_en,
    output logic [W-1:0]  pin_pol,
    output logic [W-1:0]  pull_en,
    output logic          irq
);
    logic ie_q, flag_q, ack;

    assign ack = wr && addr == ADDR_CTRL && wdata[CTRL_ACK];

    // Hold the software-written configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            pin_en  <= '0;
            pin_pol <= '0;
            pull_en <= '0;
        end else if (wr) begin
            case (addr)
                ADDR_CTRL: ie_q    <= wdata[CTRL_IE];
                ADDR_EN:   pin_en  <= wdata[W-1:0];
                ADDR_POL:  pin_pol <= wdata[W-1:0];
                ADDR_PULL: pull_en <= wdata[W-1:0];
                default:   ;
            endcase
        end
    end

    // Sticky flag: a new edge outranks an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= hit_any | (flag_q & ~ack);
    end

    // Return the addressed word; ack always reads as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                rdata[CTRL_IE]   = ie_q;
                rdata[CTRL_FLAG] = flag_q;
            end
            ADDR_EN:   rdata[W-1:0] = pin_en;
            ADDR_POL:  rdata[W-1:0] = pin_pol;
            ADDR_PULL: rdata[W-1:0] = pull_en;
            default:   ;
        endcase
    end

    assign irq = flag_q & ie_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!flag_q && !ie_q && pin_en == '0));
    assert_edge_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> flag_q);
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit_any) |=> !flag_q);
    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_any && ie_q && !(wr && addr == ADDR_CTRL)) |=> irq);
endmodule

// File: rtl/keypin_irq_ctrl.sv
// Top of the keyboard pin edge interrupt controller: synchronizer,
// edge detector, register file and pull direction outputs.
// Assumes pins_in is asynchronous and the register port is synchronous.
module keypin_irq_ctrl
    import kpi_pkg::*;
#(
    parameter int NPINS = KPI_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [KPI_AW-1:0] reg_addr,
    input  logic [KPI_DW-1:0] reg_wdata,
    output logic [KPI_DW-1:0] reg_rdata,
    input  logic [NPINS-1:0]  pins_in,
    output logic [NPINS-1:0]  pull_up,
    output logic [NPINS-1:0]  pull_down,
    output logic              irq
);
    logic [NPINS-1:0] smp, hit, pin_en, pin_pol, pull_en;

    kpi_sync #(.W(NPINS), .STAGES(KPI_SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_in), .q(smp));

    kpi_edge #(.W(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .smp(smp), .en(pin_en),
        .pol(pin_pol), .hit(hit));

    kpi_regs #(.W(NPINS), .DW(KPI_DW), .AW(KPI_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .hit_any(|hit),
        .pin_en(pin_en), .pin_pol(pin_pol), .pull_en(pull_en), .irq(irq));

    // One polarity bit steers both the active edge and the pull direction.
    always_comb begin
        pull_up   = pull_en & ~pin_pol;
        pull_down = pull_en & pin_pol;
    end

    assert_pull_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up & pull_down) == '0);
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~pin_en) == '0);
endmodule

// File: tb/tb_keypin_irq_ctrl.sv
module tb_keypin_irq_ctrl;
    localparam time CYC = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] pins_in = 4'hF;
    logic [3:0] pull_up, pull_down;
    logic       irq;

    keypin_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pins_in(pins_in),
        .pull_up(pull_up), .pull_down(pull_down), .irq(irq));

    always #(CYC/2) clk = ~clk;

    typedef struct {
        int         kind;   // 0 read data, 1 irq, 2 {pull_down, pull_up}
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = reg_rdata;
                    1:       act = {7'd0, irq};
                    default: act = {pull_down, pull_up};
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [7:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        ->chk_ev;
        #2;
    endtask

    task automatic exp_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        push(0, exp, tag);
    endtask

    task automatic exp_irq(input logic exp, input string tag);
        @(negedge clk);
        push(1, {7'd0, exp}, tag);
    endtask

    task automatic exp_pull(input logic [7:0] exp, input string tag);
        @(negedge clk);
        push(2, exp, tag);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_pins(input logic [3:0] p);
        @(negedge clk);
        pins_in = p;
        repeat (4) @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CYC * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R1 reset state
        exp_read(2'd0, 8'h00, "R1 ctrl after reset");
        exp_read(2'd1, 8'h00, "R1 enables after reset");
        exp_read(2'd3, 8'h00, "R1 pulls after reset");
        exp_irq(1'b0, "R1 irq after reset");
        exp_pull(8'h00, "R1 pull outputs after reset");

        // R8 and R10 pull direction and readback
        wr_reg(2'd3, 8'h03);
        wr_reg(2'd2, 8'h02);
        exp_pull(8'h21, "R8 pin0 up pin1 down");
        exp_read(2'd2, 8'h02, "R10 polarity readback");
        exp_read(2'd3, 8'h03, "R10 pull readback");
        wr_reg(2'd0, 8'h02);
        exp_read(2'd0, 8'h00, "R6 ack reads zero");

        // R9 enable steady pin0 (falling polarity), masked
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd1, 8'h01);
        repeat (4) @(posedge clk);
        exp_read(2'd0, 8'h00, "R9 enable steady pin no flag");

        // R2 falling edge on pin0 with interrupt masked
        set_pins(4'b1110);
        exp_read(2'd0, 8'h04, "R2 falling edge sets flag");
        exp_irq(1'b0, "R5 masked irq");
        wr_reg(2'd0, 8'h01);
        exp_irq(1'b1, "R5 unmasked irq");
        exp_read(2'd0, 8'h05, "R5 ctrl with ie");

        // R6 acknowledge
        wr_reg(2'd0, 8'h03);
        exp_read(2'd0, 8'h01, "R6 ack clears flag");
        exp_irq(1'b0, "R6 irq drops");

        // R4 opposite edge and disabled pin
        set_pins(4'b1111);
        exp_read(2'd0, 8'h01, "R4 opposite edge ignored");
        set_pins(4'b0111);
        set_pins(4'b1111);
        exp_read(2'd0, 8'h01, "R4 disabled pin ignored");

        // R3 rising polarity on pin1 (currently high)
        wr_reg(2'd2, 8'h02);
        wr_reg(2'd1, 8'h03);
        repeat (4) @(posedge clk);
        exp_read(2'd0, 8'h01, "R9 enable high pin rising pol no flag");
        set_pins(4'b1101);
        exp_read(2'd0, 8'h01, "R4 falling on rising pin ignored");
        set_pins(4'b1111);
        exp_read(2'd0, 8'h05, "R3 rising edge sets flag");
        exp_irq(1'b1, "R5 irq with flag");

        // R7 edge and ack in the same cycle
        set_pins(4'b1101);
        @(negedge clk);
        pins_in = 4'b1111;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h03;
        @(negedge clk);
        reg_wr = 1'b0;
        exp_read(2'd0, 8'h05, "R7 edge beats ack");
        wr_reg(2'd0, 8'h03);
        exp_read(2'd0, 8'h01, "R6 later ack clears");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule